// File: doc/BRIEF.md
# Pseudo-Program March Self-Test Sequencer for a Fuse Array

This block is a built-in self-test sequencer for a one-time-programmable fuse array of ROWS by COLS cells. A write-once array cannot take the alternating data that march tests rely on. The sequencer therefore creates a non-destructive "programmed" condition instead. On the addressed cell it opens the program path and the sense path together, and it keeps the program supply at its low, non-programming level. That cell must then sense 1, even when it is virgin. A plain read, with only the sense path open, must return 0 from an unprogrammed cell. By alternating these two kinds of access, the sequencer applies a march test to every cell.

A single-cycle start pulse launches three march elements:

- **Element 0:** ascending order. Each cell gets a plain read, then a pseudo-programmed read.
- **Element 1:** descending order. Each cell gets a pseudo-programmed read, then a plain read.
- **Element 2:** ascending order. Each cell gets one plain read.

Every access takes four clock cycles: select, settle, sense, capture. The block drives the active-low wordlines, the per-column program and sense pass gates, and the sense-amplifier enable. In the capture cycle it compares the latched sense value with the expected value.

The first mismatch is recorded: row, column, element number and expected value. A recorded expected value of 0 means a virgin cell read as programmed, which is an accidental program. After a mismatch the run either stops or runs to the end, depending on a stop-on-fail input. The high-voltage supply select is forced low for the whole run.

Top module: `otp_march_bist`

## Requirements
- R1: After reset, every wordline is high (inactive), all pass gates and the sense enable are low, and done, pass and fail are 0.
- R2: Each access lasts exactly four cycles. Its wordline and sense pass gate are active in the first three cycles. The sense enable is high only in the third cycle. In the fourth (capture) cycle everything is released, so the address never changes while a gate is open.
- R3: A plain read opens the sense pass gate of the addressed column only, leaves every program pass gate closed, and expects the sensed bit to be 0.
- R4: A pseudo-programmed read opens the program and sense pass gates of the same column together, and expects the sensed bit to be 1.
- R5: The accesses follow this order, 5·ROWS·COLS accesses in all. Element 0 runs ascending (column fastest), with a plain read then a pseudo read per cell. Element 1 runs descending from the last cell, with a pseudo read then a plain read per cell. Element 2 runs ascending with one plain read per cell.
- R6: While a test runs, hv_sel is 0 whatever hv_req does. While the sequencer is idle, hv_sel follows hv_req.
- R7: At most one wordline is low and at most one column's gates are open in any cycle.
- R8: The first capture whose sensed bit differs from the expected bit sets fail and records its row, column, element number (0, 1 or 2) and expected bit. Later mismatches in the same run leave the record unchanged.
- R9: With stop_on_fail = 1, the run ends right after the first failing capture. With stop_on_fail = 0, the run completes all accesses.
- R10: Done rises when the run ends and stays high until the next accepted start. A start pulse while a run is in progress is ignored. Pass equals done with no recorded failure.
- R11: An accepted start clears fail and the recorded failure fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle pulse that launches a test run |
| stop_on_fail | input | 1 | 1: end the run at the first mismatch |
| hv_req | input | 1 | High-voltage request from the normal program path |
| sense_data | input | 1 | Latched sense-amplifier output, valid in the capture cycle |
| row_sel_n | output | ROWS | Active-low wordlines |
| wr_gate | output | COLS | Program-path column pass gates |
| rd_gate | output | COLS | Sense-path column pass gates |
| sa_en | output | 1 | Sense-amplifier enable |
| hv_sel | output | 1 | High program-supply select |
| done | output | 1 | Run finished; held until the next start |
| pass | output | 1 | Run finished with no mismatch |
| fail | output | 1 | A mismatch has been recorded |
| fail_row | output | RW | Row of the first mismatch |
| fail_col | output | CW | Column of the first mismatch |
| fail_elem | output | 2 | March element of the first mismatch |
| fail_exp | output | 1 | Expected bit of the first mismatch |

## Verification
Faults that appear only from a chosen access onward let the bench place the first mismatch inside each march element. An address counter that stepped wrongly would surface at once, on the wordline or gate pattern of the next access. A wrong element or direction would show up within one access as a trace mismatch, and also as wrong recorded fields and a wrong access count once done rises. A sequencing fault in the four-cycle phase would be seen within that same access, as a wrong sense-enable position or a select window of the wrong length.

// File: rtl/otp_march_pkg.sv
package otp_march_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SEL    = 3'd1,
        PH_SETTLE = 3'd2,
        PH_SENSE  = 3'd3,
        PH_CAPT   = 3'd4
    } phase_t;

    typedef logic [1:0] elem_t;

    localparam elem_t LAST_ELEM = 2'd2;

    // Pseudo-programmed access: second op of element 0, first op of element 1.
    function automatic logic op_is_pseudo(elem_t e, logic op);
        return ((e == 2'd0) && op) || ((e == 2'd1) && !op);
    endfunction

    // Element 2 performs one op per cell, the others two.
    function automatic logic op_is_last(elem_t e, logic op);
        return (e == LAST_ELEM) ? 1'b1 : op;
    endfunction

    function automatic logic elem_descends(elem_t e);
        return e == 2'd1;
    endfunction

    function automatic logic phase_open(phase_t p);
        return (p == PH_SEL) || (p == PH_SETTLE) || (p == PH_SENSE);
    endfunction

endpackage

// File: rtl/march_seq.sv
module march_seq
    import otp_march_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int RW   = 2,
    parameter int CW   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          halt,
    output phase_t        phase,
    output logic [RW-1:0] row,
    output logic [CW-1:0] col,
    output elem_t         elem,
    output logic          op,
    output logic          done,
    output logic          clear
);
    localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
    localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

    logic desc;
    logic cell_last;
    logic next_desc;

    assign clear     = (phase == PH_IDLE) && start;
    assign desc      = elem_descends(elem);
    assign next_desc = elem_descends(elem + 2'd1);
    assign cell_last = desc ? ((row == '0) && (col == '0))
                            : ((row == ROW_LAST) && (col == COL_LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            row   <= '0;
            col   <= '0;
            elem  <= '0;
            op    <= 1'b0;
            done  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_SEL;
                        row   <= '0;
                        col   <= '0;
                        elem  <= '0;
                        op    <= 1'b0;
                        done  <= 1'b0;
                    end
                end
                PH_SEL:    phase <= PH_SETTLE;
                PH_SETTLE: phase <= PH_SENSE;
                PH_SENSE:  phase <= PH_CAPT;
                PH_CAPT: begin
                    if (halt) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else if (!op_is_last(elem, op)) begin
                        op    <= 1'b1;
                        phase <= PH_SEL;
                    end else begin
                        op <= 1'b0;
                        if (cell_last) begin
                            if (elem == LAST_ELEM) begin
                                phase <= PH_IDLE;
                                done  <= 1'b1;
                            end else begin
                                elem  <= elem + 2'd1;
                                row   <= next_desc ? ROW_LAST : '0;
                                col   <= next_desc ? COL_LAST : '0;
                                phase <= PH_SEL;
                            end
                        end else begin
                            phase <= PH_SEL;
                            if (desc) begin
                                if (col == '0) begin
                                    col <= COL_LAST;
                                    row <= row - 1'b1;
                                end else begin
                                    col <= col - 1'b1;
                                end
                            end else begin
                                if (col == COL_LAST) begin
                                    col <= '0;
                                    row <= row + 1'b1;
                                end else begin
                                    col <= col + 1'b1;
                                end
                            end
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assert_sel_to_settle_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SEL) |=> (phase == PH_SETTLE));
    assert_settle_to_sense_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SETTLE) |=> (phase == PH_SENSE));
    assert_sense_to_capt_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SENSE) |=> (phase == PH_CAPT));
    assert_addr_held_R2: assert property (@(posedge clk) disable iff (rst)
        phase_open(phase) |=> ($stable(row) && $stable(col) && $stable(op)));
    assert_done_held_R10: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
    assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (phase_open(phase) && start) |=> !done);

endmodule

// File: rtl/march_sel_decode.sv
module march_sel_decode
    import otp_march_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int RW   = 2,
    parameter int CW   = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  phase_t          phase,
    input  logic [RW-1:0]   row,
    input  logic [CW-1:0]   col,
    input  elem_t           elem,
    input  logic            op,
    output logic [ROWS-1:0] row_sel_n,
    output logic [COLS-1:0] wr_gate,
    output logic [COLS-1:0] rd_gate,
    output logic            sa_en,
    output logic            exp_val
);
    logic open_win;
    logic pseudo;

    assign open_win = phase_open(phase);
    assign pseudo   = op_is_pseudo(elem, op);
    assign sa_en    = (phase == PH_SENSE);
    assign exp_val  = pseudo;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_sel_n[r] = !(open_win && (row == RW'(r)));
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign rd_gate[c] = open_win && (col == CW'(c));
        assign wr_gate[c] = open_win && pseudo && (col == CW'(c));
    end

    assert_one_row_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~row_sel_n));
    assert_one_col_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_gate));
    assert_sense_has_row_R2: assert property (@(posedge clk) disable iff (rst)
        sa_en |-> ($countones(~row_sel_n) == 1) && ($countones(rd_gate) == 1));
    assert_capture_released_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CAPT) |-> (&row_sel_n && (rd_gate == '0) && (wr_gate == '0)));

endmodule

// File: rtl/march_fail_log.sv
module march_fail_log
    import otp_march_pkg::*;
#(
    parameter int RW = 2,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  phase_t        phase,
    input  logic          sense_data,
    input  logic          exp_val,
    input  logic [RW-1:0] row,
    input  logic [CW-1:0] col,
    input  elem_t         elem,
    output logic          mismatch,
    output logic          fail,
    output logic [RW-1:0] fail_row,
    output logic [CW-1:0] fail_col,
    output elem_t         fail_elem,
    output logic          fail_exp
);
    assign mismatch = (phase == PH_CAPT) && (sense_data != exp_val);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fail      <= 1'b0;
            fail_row  <= '0;
            fail_col  <= '0;
            fail_elem <= '0;
            fail_exp  <= 1'b0;
        end else if (mismatch && !fail) begin
            fail      <= 1'b1;
            fail_row  <= row;
            fail_col  <= col;
            fail_elem <= elem;
            fail_exp  <= exp_val;
        end
    end

    assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (fail && !clear) |=> fail);
    assert_record_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (fail && !clear) |=> ($stable(fail_row) && $stable(fail_col)
                              && $stable(fail_elem) && $stable(fail_exp)));
    assert_mismatch_records_R8: assert property (@(posedge clk) disable iff (rst)
        (mismatch && !clear) |=> fail);
    assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
        clear |=> !fail);

endmodule

// File: rtl/otp_march_bist.sv
module otp_march_bist
    import otp_march_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            stop_on_fail,
    input  logic            hv_req,
    input  logic            sense_data,
    output logic [ROWS-1:0] row_sel_n,
    output logic [COLS-1:0] wr_gate,
    output logic [COLS-1:0] rd_gate,
    output logic            sa_en,
    output logic            hv_sel,
    output logic            done,
    output logic            pass,
    output logic            fail,
    output logic [RW-1:0]   fail_row,
    output logic [CW-1:0]   fail_col,
    output logic [1:0]      fail_elem,
    output logic            fail_exp
);
    phase_t        phase;
    logic [RW-1:0] row;
    logic [CW-1:0] col;
    elem_t         elem;
    logic          op;
    logic          clear;
    logic          mismatch;
    logic          halt;
    logic          exp_val;

    assign halt   = mismatch && stop_on_fail;
    assign hv_sel = hv_req && (phase == PH_IDLE);
    assign pass   = done && !fail;

    march_seq #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .halt  (halt),
        .phase (phase),
        .row   (row),
        .col   (col),
        .elem  (elem),
        .op    (op),
        .done  (done),
        .clear (clear)
    );

    march_sel_decode #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .row       (row),
        .col       (col),
        .elem      (elem),
        .op        (op),
        .row_sel_n (row_sel_n),
        .wr_gate   (wr_gate),
        .rd_gate   (rd_gate),
        .sa_en     (sa_en),
        .exp_val   (exp_val)
    );

    march_fail_log #(.RW(RW), .CW(CW)) u_log (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .phase      (phase),
        .sense_data (sense_data),
        .exp_val    (exp_val),
        .row        (row),
        .col        (col),
        .elem       (elem),
        .mismatch   (mismatch),
        .fail       (fail),
        .fail_row   (fail_row),
        .fail_col   (fail_col),
        .fail_elem  (fail_elem),
        .fail_exp   (fail_exp)
    );

    assert_no_hv_in_test_R6: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |-> !hv_sel);
    assert_halt_ends_run_R9: assert property (@(posedge clk) disable iff (rst)
        halt |=> done);

endmodule

// File: tb/otp_march_bist_bench.sv
`timescale 1ns/1ps
module otp_march_bist_bench;
    localparam int ROWS  = 4;
    localparam int COLS  = 4;
    localparam int TOTAL = 5 * ROWS * COLS;

    typedef struct packed {
        logic       s1_en;   // cell stuck at high resistance: plain read gives 1
        logic [3:0] s1_idx;
        logic       s0_en;   // cell whose pseudo read gives 0
        logic [3:0] s0_idx;
        logic [7:0] arm;     // faults act from this access number (1-based)
        logic       stop;
        logic       x_fail;
        logic [1:0] x_row;
        logic [1:0] x_col;
        logic [1:0] x_elem;
        logic       x_val;
        logic [7:0] x_count;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{1'b0, 4'd0,  1'b0, 4'd0,  8'd0,  1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 8'd80},
        '{1'b1, 4'd5,  1'b0, 4'd0,  8'd0,  1'b1, 1'b1, 2'd1, 2'd1, 2'd0, 1'b0, 8'd11},
        '{1'b0, 4'd0,  1'b1, 4'd10, 8'd0,  1'b1, 1'b1, 2'd2, 2'd2, 2'd0, 1'b1, 8'd22},
        '{1'b1, 4'd15, 1'b0, 4'd0,  8'd0,  1'b0, 1'b1, 2'd3, 2'd3, 2'd0, 1'b0, 8'd80},
        '{1'b1, 4'd3,  1'b1, 4'd12, 8'd0,  1'b0, 1'b1, 2'd0, 2'd3, 2'd0, 1'b0, 8'd80},
        '{1'b0, 4'd0,  1'b1, 4'd15, 8'd33, 1'b1, 1'b1, 2'd3, 2'd3, 2'd1, 1'b1, 8'd33},
        '{1'b1, 4'd0,  1'b0, 4'd0,  8'd65, 1'b1, 1'b1, 2'd0, 2'd0, 2'd2, 1'b0, 8'd65},
        '{1'b1, 4'd14, 1'b0, 4'd0,  8'd33, 1'b0, 1'b1, 2'd3, 2'd2, 2'd1, 1'b0, 8'd80}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic            stop_on_fail = 1'b0;
    logic            hv_req = 1'b1;
    logic            sense_data = 1'b0;
    logic [ROWS-1:0] row_sel_n;
    logic [COLS-1:0] wr_gate;
    logic [COLS-1:0] rd_gate;
    logic            sa_en;
    logic            hv_sel;
    logic            done;
    logic            pass;
    logic            fail;
    logic [1:0]      fail_row;
    logic [1:0]      fail_col;
    logic [1:0]      fail_elem;
    logic            fail_exp;

    int checks = 0;
    int errors = 0;

    vec_t cur;
    int   acc_cnt = 0;
    int   trace_err = 0;
    int   shape_err = 0;
    int   sel_err = 0;
    int   hv_err = 0;
    int   open_len = 0;
    int   exp_r [TOTAL];
    int   exp_c [TOTAL];
    int   exp_p [TOTAL];

    always #4 clk = ~clk;

    otp_march_bist #(.ROWS(ROWS), .COLS(COLS)) u_otp_march_bist (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .stop_on_fail (stop_on_fail),
        .hv_req       (hv_req),
        .sense_data   (sense_data),
        .row_sel_n    (row_sel_n),
        .wr_gate      (wr_gate),
        .rd_gate      (rd_gate),
        .sa_en        (sa_en),
        .hv_sel       (hv_sel),
        .done         (done),
        .pass         (pass),
        .fail         (fail),
        .fail_row     (fail_row),
        .fail_col     (fail_col),
        .fail_elem    (fail_elem),
        .fail_exp     (fail_exp)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Array and latching sense-amplifier model; also checks access order (R5).
    always @(posedge clk) begin
        if (sa_en) begin : snap
            int   r;
            int   c;
            int   idx;
            logic pz;
            logic armed;
            logic v;
            r = -1;
            c = -1;
            for (int i = 0; i < ROWS; i++) if (!row_sel_n[i]) r = i;
            for (int i = 0; i < COLS; i++) if (rd_gate[i]) c = i;
            pz    = |wr_gate;
            idx   = r * COLS + c;
            armed = (acc_cnt + 1) >= int'(cur.arm);
            if (pz) v = !(armed && cur.s0_en && (int'(cur.s0_idx) == idx));
            else    v = armed && cur.s1_en && (int'(cur.s1_idx) == idx);
            sense_data <= v;
            if (acc_cnt < TOTAL) begin
                if (r != exp_r[acc_cnt] || c != exp_c[acc_cnt] || int'(pz) != exp_p[acc_cnt])
                    trace_err++;
            end else begin
                trace_err++;
            end
            acc_cnt++;
        end
    end

    // Pin-level access shape monitor (R2, R3, R4, R7).
    always @(negedge clk) begin
        if (!rst) begin
            if (!(&row_sel_n)) begin
                open_len++;
                if (sa_en != (open_len == 3)) shape_err++;
                if ($countones(~row_sel_n) != 1) sel_err++;
                if ($countones(rd_gate) != 1) sel_err++;
                if (wr_gate != '0 && wr_gate != rd_gate) sel_err++;
            end else begin
                if (open_len != 0 && open_len != 3) shape_err++;
                open_len = 0;
                if (sa_en || rd_gate != '0 || wr_gate != '0) shape_err++;
            end
        end
    end

    task automatic build_trace();
        int n = 0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                exp_r[n] = r; exp_c[n] = c; exp_p[n] = 0; n++;
                exp_r[n] = r; exp_c[n] = c; exp_p[n] = 1; n++;
            end
        for (int r = ROWS - 1; r >= 0; r--)
            for (int c = COLS - 1; c >= 0; c--) begin
                exp_r[n] = r; exp_c[n] = c; exp_p[n] = 1; n++;
                exp_r[n] = r; exp_c[n] = c; exp_p[n] = 0; n++;
            end
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                exp_r[n] = r; exp_c[n] = c; exp_p[n] = 0; n++;
            end
    endtask

    // Launch one run; optionally pulse start again mid-run; wait for done.
    task automatic run(input vec_t v, input bit restart_mid);
        int cyc = 0;
        cur          = v;
        stop_on_fail = v.stop;
        acc_cnt      = 0;
        trace_err    = 0;
        hv_err       = 0;
        start        = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 2000) begin
            if (hv_sel) hv_err++;
            if (restart_mid && cyc == 37) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk("R10 done reached before timeout", int'(cyc < 2000), 1);
        chk("R6 hv_sel low during run", hv_err, 0);
    endtask

    task automatic check_result(input vec_t v, input int n);
        string tag;
        tag = $sformatf("vector %0d", n);
        chk({"R5/R9 access count ", tag}, acc_cnt, int'(v.x_count));
        chk({"R5 access order ", tag}, trace_err, 0);
        chk({"R8 fail flag ", tag}, int'(fail), int'(v.x_fail));
        chk({"R10 pass flag ", tag}, int'(pass), int'(!v.x_fail));
        if (v.x_fail) begin
            chk({"R8 fail_row ", tag}, int'(fail_row), int'(v.x_row));
            chk({"R8 fail_col ", tag}, int'(fail_col), int'(v.x_col));
            chk({"R8 fail_elem ", tag}, int'(fail_elem), int'(v.x_elem));
            chk({"R8 fail_exp ", tag}, int'(fail_exp), int'(v.x_val));
        end
    endtask

    initial begin : watchdog
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        vec_t v;
        build_trace();
        cur = VECS[0];
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 wordlines inactive", int'(&row_sel_n), 1);
        chk("R1 sense gates closed", int'(rd_gate), 0);
        chk("R1 program gates closed", int'(wr_gate), 0);
        chk("R1 sense enable low", int'(sa_en), 0);
        chk("R1 done low", int'(done), 0);
        chk("R1 pass low", int'(pass), 0);
        chk("R1 fail low", int'(fail), 0);
        chk("R6 hv_sel follows hv_req when idle", int'(hv_sel), 1);

        // Vector table
        for (int i = 0; i < 8; i++) begin
            v = VECS[i];
            run(v, 1'b0);
            check_result(v, i);
            chk("R2 access phase shape", shape_err, 0);
            chk("R3/R4/R7 gate selection", sel_err, 0);
        end

        // R10 done held, R6 hv_sel back in idle
        repeat (20) @(negedge clk);
        chk("R10 done held until next start", int'(done), 1);
        chk("R6 hv_sel follows hv_req after run", int'(hv_sel), 1);
        hv_req = 1'b0;
        @(negedge clk);
        chk("R6 hv_sel drops with hv_req", int'(hv_sel), 0);
        hv_req = 1'b1;

        // R11 clean run after a failing run clears the record
        v = VECS[0];
        run(v, 1'b0);
        chk("R11 fail cleared by start", int'(fail), 0);
        chk("R11 fail_row cleared", int'(fail_row), 0);
        chk("R11 fail_elem cleared", int'(fail_elem), 0);
        chk("R11 pass after clean run", int'(pass), 1);

        // R10 start pulse during a run is ignored
        run(v, 1'b1);
        chk("R10 start while busy ignored: count", acc_cnt, TOTAL);
        chk("R10 start while busy ignored: order", trace_err, 0);
        chk("R2 access phase shape final", shape_err, 0);
        chk("R7 gate selection final", sel_err, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule